// File: doc/BRIEF.md
# Battery Pack Protection Fault Policy Engine

This block sits between the digital outputs of a pack's analog comparators and the charge and discharge switch drivers. Seven condition flags arrive from outside: over-voltage, under-voltage, over-current, short-circuit, over-temperature, reverse polarity and backfeed. Each flag gets its own reaction. A qualification step either counts consecutive samples or is skipped. A first action can leave the path on while asking for current limiting or derating. A final action opens the path. A release rule can be a clear request, a charger wake, a cool-down or a quiet timeout. The engine drives the two switch enables and an active-low fault line. It records the code of the most recent trip and keeps one saturating event counter per fault type.

The engine is one state machine with ten named states. The normal state is ST_RUN. Three pending states keep the switches on while a slow fault is confirmed: ST_UV_WAIT, ST_OC_LIMIT and ST_OT_DERATE. Six off states hold the switches open: ST_SC_LATCH, ST_OV_LATCH, ST_UV_OFF, ST_OC_OFF, ST_OT_OFF and ST_ISOLATE.

Every trip goes from the current state to the state that belongs to the winning code. Under-voltage goes to ST_UV_WAIT, over-current to ST_OC_LIMIT, over-temperature to ST_OT_DERATE, over-voltage to ST_OV_LATCH, short to ST_SC_LATCH, and reverse polarity or backfeed to ST_ISOLATE. The remaining transitions are named in the requirements:
- Pending rebound: a pending state returns to ST_RUN when its flag drops.
- Pending expiry: a pending state moves to its off state when its delay runs out.
- Release: an off state returns to ST_RUN under its own rule.

All debounce lengths and delays are parameters counted in clock cycles. The defaults are small so that simulation stays short.

Top module: `pfp_engine`

## Requirements
- R1: A debounced flag (all flags except short) is qualified after it has been sampled high on N consecutive rising edges, where N is its debounce parameter. The engine trips on the following edge. A flag sampled low before qualification restarts its count from zero, so that no trip results.
- R2: An over-voltage trip opens both switches, sets fault_code to 4 and latches in ST_OV_LATCH. It returns to ST_RUN only on an edge where clear_req and ov_hys_ok are both high. A clear_req with ov_hys_ok low has no effect.
- R3: An under-voltage trip enters ST_UV_WAIT with both switches still closed and fault_code 7. The switches open after UV_DLY cycles if the debounced flag persists, and the engine returns to ST_RUN if the flag drops first. From ST_UV_OFF only charger_wake returns it to ST_RUN.
- R4: An over-current trip raises ilim_req with both switches closed and fault_code 6. After OC_DLY cycles of a persisting debounced flag, both switches open and ilim_req falls. From ST_OC_OFF a clear_req returns the engine to ST_RUN.
- R5: flag_short bypasses debounce. It opens both switches on the first rising edge that samples it, from any state, and sets fault_code 1. ST_SC_LATCH is left only on an edge with clear_req high and flag_short low.
- R6: An over-temperature trip raises derate_req with the switches closed and fault_code 5. After OT_DLY cycles of a persisting debounced flag, both switches open. The engine retries to ST_RUN automatically on the first edge that samples flag_ot low.
- R7: A reverse-polarity trip (fault_code 2) or a backfeed trip (fault_code 3) opens both switches in ST_ISOLATE. The engine returns to ST_RUN after ISO_HOLD consecutive edges with both flag_rev and flag_bkf low.
- R8: fault_n is high in ST_RUN and low in every other state.
- R9: fault_code holds the code of the most recent trip, and 0 after reset. When several qualified faults compete, the lowest code wins (priority 1 to 7). In ST_RUN any fault trips. In a pending state only a fault with a lower code than the current one preempts. In an off state only a short preempts.
- R10: Every trip increments the counter of its code. The counter for code k sits at evt_counts[(k-1)*CNT_W +: CNT_W] and saturates at 2^CNT_W-1 instead of wrapping.
- R11: After reset the engine is in ST_RUN. Both switches are enabled, ilim_req and derate_req are low, fault_n is high, fault_code is 0 and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_ov | input | 1 | Over-voltage comparator flag |
| ov_hys_ok | input | 1 | Pack voltage is below the over-voltage release level |
| flag_uv | input | 1 | Under-voltage comparator flag |
| flag_oc | input | 1 | Filtered over-current comparator flag |
| flag_short | input | 1 | Short-circuit comparator flag (not debounced) |
| flag_ot | input | 1 | Over-temperature flag; low means cooled down |
| flag_rev | input | 1 | Reverse-polarity detect flag |
| flag_bkf | input | 1 | Backfeed (reverse current) detect flag |
| clear_req | input | 1 | Fault clear request |
| charger_wake | input | 1 | Charger attach wake event |
| chg_en | output | 1 | Charge switch enable |
| dsg_en | output | 1 | Discharge switch enable |
| ilim_req | output | 1 | Current-limit request |
| derate_req | output | 1 | Thermal derating request |
| fault_n | output | 1 | Active-low fault indication |
| fault_code | output | 3 | Code of the most recent trip (0 none, 1 short, 2 reverse, 3 backfeed, 4 OV, 5 OT, 6 OC, 7 UV) |
| evt_counts | output | 7*CNT_W | Saturating per-code event counters, code k in slice k-1 |

## Verification
The assertions assume that all inputs are synchronous to clk and change only away from its rising edge. They also assume that every debounce length and delay parameter is at least 1, and that the ov_hys_ok and flag_short inputs are meaningful on every cycle. The bench drives every input at the falling edge and holds it for whole cycles. It keeps flags high for exact cycle counts, so each qualification, each delay expiry and each release lands on a known edge. Competing faults are raised together or during a pending state to exercise priority and preemption. A running reference model checks every output on every cycle against the same stimulus.

// File: rtl/pfp_pkg.sv
package pfp_pkg;

    typedef enum logic [3:0] {
        ST_RUN,
        ST_UV_WAIT,
        ST_OC_LIMIT,
        ST_OT_DERATE,
        ST_SC_LATCH,
        ST_OV_LATCH,
        ST_UV_OFF,
        ST_OC_OFF,
        ST_OT_OFF,
        ST_ISOLATE
    } pfp_state_e;

    // Fault codes; a lower code has higher priority.
    localparam logic [2:0] CODE_NONE = 3'd0;
    localparam logic [2:0] CODE_SC   = 3'd1;
    localparam logic [2:0] CODE_REV  = 3'd2;
    localparam logic [2:0] CODE_BKF  = 3'd3;
    localparam logic [2:0] CODE_OV   = 3'd4;
    localparam logic [2:0] CODE_OT   = 3'd5;
    localparam logic [2:0] CODE_OC   = 3'd6;
    localparam logic [2:0] CODE_UV   = 3'd7;

    localparam int NUM_CODES = 7;
    // Debounced channels: index i carries code i+2.
    localparam int NUM_DEB   = 6;

endpackage

// File: rtl/pfp_debounce.sv
module pfp_debounce #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag,
    output logic qual
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!flag) begin
            cnt <= '0;
        end else if (cnt != CW'(LIMIT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign qual = (cnt == CW'(LIMIT));

    AST_DEB_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !flag |=> !qual); // R1
    AST_DEB_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qual) |-> $past(flag)); // R1

endmodule

// File: rtl/pfp_sat_counter.sv
module pfp_sat_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && count != TOP) begin
            count <= count + 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && count == TOP) |=> (count == TOP)); // R10
    AST_CNT_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count >= $past(count))); // R10

endmodule

// File: rtl/pfp_engine.sv
module pfp_engine
    import pfp_pkg::*;
#(
    parameter int DEB_OV   = 4,
    parameter int DEB_UV   = 6,
    parameter int DEB_OC   = 3,
    parameter int DEB_OT   = 5,
    parameter int DEB_REV  = 2,
    parameter int DEB_BKF  = 3,
    parameter int UV_DLY   = 10,
    parameter int OC_DLY   = 8,
    parameter int OT_DLY   = 12,
    parameter int ISO_HOLD = 6,
    parameter int CNT_W    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flag_ov,
    input  logic                       ov_hys_ok,
    input  logic                       flag_uv,
    input  logic                       flag_oc,
    input  logic                       flag_short,
    input  logic                       flag_ot,
    input  logic                       flag_rev,
    input  logic                       flag_bkf,
    input  logic                       clear_req,
    input  logic                       charger_wake,
    output logic                       chg_en,
    output logic                       dsg_en,
    output logic                       ilim_req,
    output logic                       derate_req,
    output logic                       fault_n,
    output logic [2:0]                 fault_code,
    output logic [NUM_CODES*CNT_W-1:0] evt_counts
);
    localparam int MAX_A   = (UV_DLY > OC_DLY) ? UV_DLY : OC_DLY;
    localparam int MAX_B   = (OT_DLY > ISO_HOLD) ? OT_DLY : ISO_HOLD;
    localparam int TMR_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TW      = $clog2(TMR_MAX + 1);

    function automatic int deb_limit(input int idx);
        case (idx)
            0:       return DEB_REV;
            1:       return DEB_BKF;
            2:       return DEB_OV;
            3:       return DEB_OT;
            4:       return DEB_OC;
            default: return DEB_UV;
        endcase
    endfunction

    function automatic pfp_state_e trip_target(input logic [2:0] code);
        case (code)
            CODE_SC:           return ST_SC_LATCH;
            CODE_REV, CODE_BKF: return ST_ISOLATE;
            CODE_OV:           return ST_OV_LATCH;
            CODE_OT:           return ST_OT_DERATE;
            CODE_OC:           return ST_OC_LIMIT;
            default:           return ST_UV_WAIT;
        endcase
    endfunction

    // ---------------- qualification ----------------
    logic [NUM_DEB-1:0] deb_in;
    logic [NUM_DEB-1:0] qual;

    assign deb_in = {flag_uv, flag_oc, flag_ot, flag_ov, flag_bkf, flag_rev};

    for (genvar g = 0; g < NUM_DEB; g++) begin : g_deb
        pfp_debounce #(.LIMIT(deb_limit(g))) u_deb (
            .clk  (clk),
            .rst_n(rst_n),
            .flag (deb_in[g]),
            .qual (qual[g])
        );
    end

    // Highest-priority pending request (lowest code).
    logic [2:0] pick;
    always_comb begin
        pick = CODE_NONE;
        for (int i = NUM_DEB - 1; i >= 0; i--) begin
            if (qual[i]) pick = 3'(i + 2);
        end
        if (flag_short) pick = CODE_SC;
    end

    // ---------------- state machine ----------------
    pfp_state_e     st, st_nxt;
    logic [TW-1:0]  tmr, tmr_nxt;
    logic           pending, trip;

    assign pending = (st == ST_UV_WAIT) || (st == ST_OC_LIMIT) || (st == ST_OT_DERATE);
    assign trip    = (flag_short && st != ST_SC_LATCH)
                   || ((pick != CODE_NONE) && ((st == ST_RUN) || (pending && pick < fault_code)));

    always_comb begin
        st_nxt  = st;
        tmr_nxt = tmr;
        if (trip) begin
            st_nxt = trip_target(pick);
        end else begin
            unique case (st)
                ST_RUN: ;
                ST_UV_WAIT: begin
                    if (!qual[5])                     st_nxt = ST_RUN;
                    else if (tmr == TW'(UV_DLY - 1))  st_nxt = ST_UV_OFF;
                    else                              tmr_nxt = tmr + 1'b1;
                end
                ST_OC_LIMIT: begin
                    if (!qual[4])                     st_nxt = ST_RUN;
                    else if (tmr == TW'(OC_DLY - 1))  st_nxt = ST_OC_OFF;
                    else                              tmr_nxt = tmr + 1'b1;
                end
                ST_OT_DERATE: begin
                    if (!qual[3])                     st_nxt = ST_RUN;
                    else if (tmr == TW'(OT_DLY - 1))  st_nxt = ST_OT_OFF;
                    else                              tmr_nxt = tmr + 1'b1;
                end
                ST_SC_LATCH: if (clear_req && !flag_short) st_nxt = ST_RUN;
                ST_OV_LATCH: if (clear_req && ov_hys_ok)   st_nxt = ST_RUN;
                ST_UV_OFF:   if (charger_wake)             st_nxt = ST_RUN;
                ST_OC_OFF:   if (clear_req)                st_nxt = ST_RUN;
                ST_OT_OFF:   if (!flag_ot)                 st_nxt = ST_RUN;
                ST_ISOLATE: begin
                    if (flag_rev || flag_bkf)           tmr_nxt = '0;
                    else if (tmr == TW'(ISO_HOLD - 1))  st_nxt = ST_RUN;
                    else                                tmr_nxt = tmr + 1'b1;
                end
                default: st_nxt = ST_RUN;
            endcase
        end
        if (st_nxt != st) tmr_nxt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_RUN;
            tmr <= '0;
        end else begin
            st  <= st_nxt;
            tmr <= tmr_nxt;
        end
    end

    always_comb begin
        chg_en     = 1'b0;
        dsg_en     = 1'b0;
        ilim_req   = 1'b0;
        derate_req = 1'b0;
        fault_n    = 1'b0;
        unique case (st)
            ST_RUN: begin
                chg_en = 1'b1; dsg_en = 1'b1; fault_n = 1'b1;
            end
            ST_UV_WAIT: begin
                chg_en = 1'b1; dsg_en = 1'b1;
            end
            ST_OC_LIMIT: begin
                chg_en = 1'b1; dsg_en = 1'b1; ilim_req = 1'b1;
            end
            ST_OT_DERATE: begin
                chg_en = 1'b1; dsg_en = 1'b1; derate_req = 1'b1;
            end
            ST_SC_LATCH, ST_OV_LATCH, ST_UV_OFF, ST_OC_OFF, ST_OT_OFF, ST_ISOLATE: ;
            default: ;
        endcase
    end

    // ---------------- trip records ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    fault_code <= CODE_NONE;
        else if (trip) fault_code <= pick;
    end

    for (genvar k = 0; k < NUM_CODES; k++) begin : g_cnt
        logic bump;
        assign bump = trip && (pick == 3'(k + 1));
        pfp_sat_counter #(.W(CNT_W)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .inc  (bump),
            .count(evt_counts[k*CNT_W +: CNT_W])
        );
    end

    // ---------------- assertions ----------------
    AST_SC_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        flag_short |=> (!chg_en && !dsg_en)); // R5
    AST_OV_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OV_LATCH && !(clear_req && ov_hys_ok) && !flag_short) |=> (st == ST_OV_LATCH)); // R2
    AST_UV_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_UV_OFF && !charger_wake) |=> (!chg_en && !dsg_en)); // R3
    AST_FAULT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (!chg_en || !dsg_en || ilim_req || derate_req) |-> !fault_n); // R8
    AST_CODE_ON_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_n) |-> (fault_code != CODE_NONE)); // R9
    AST_OC_LIMIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ilim_req)) |-> (chg_en && dsg_en)); // R4

endmodule

// File: tb/tb_pfp_engine.sv
`timescale 1ns/1ps
module tb_pfp_engine;
    localparam int DEB_OV = 4, DEB_UV = 6, DEB_OC = 3, DEB_OT = 5, DEB_REV = 2, DEB_BKF = 3;
    localparam int UV_DLY = 10, OC_DLY = 8, OT_DLY = 12, ISO_HOLD = 6, CNT_W = 4;
    localparam int MAXC = (1 << CNT_W) - 1;
    localparam int LIMS [6] = '{DEB_REV, DEB_BKF, DEB_OV, DEB_OT, DEB_OC, DEB_UV};

    // bench state labels
    localparam int M_RUN = 0, M_UVW = 1, M_OCL = 2, M_OTD = 3, M_SCL = 4,
                   M_OVL = 5, M_UVO = 6, M_OCO = 7, M_OTO = 8, M_ISO = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flag_ov = 0, ov_hys_ok = 0, flag_uv = 0, flag_oc = 0, flag_short = 0;
    logic flag_ot = 0, flag_rev = 0, flag_bkf = 0, clear_req = 0, charger_wake = 0;
    logic chg_en, dsg_en, ilim_req, derate_req, fault_n;
    logic [2:0] fault_code;
    logic [7*CNT_W-1:0] evt_counts;

    always #10 clk = ~clk;

    pfp_engine #(
        .DEB_OV(DEB_OV), .DEB_UV(DEB_UV), .DEB_OC(DEB_OC), .DEB_OT(DEB_OT),
        .DEB_REV(DEB_REV), .DEB_BKF(DEB_BKF), .UV_DLY(UV_DLY), .OC_DLY(OC_DLY),
        .OT_DLY(OT_DLY), .ISO_HOLD(ISO_HOLD), .CNT_W(CNT_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .flag_ov(flag_ov), .ov_hys_ok(ov_hys_ok),
        .flag_uv(flag_uv), .flag_oc(flag_oc), .flag_short(flag_short), .flag_ot(flag_ot),
        .flag_rev(flag_rev), .flag_bkf(flag_bkf), .clear_req(clear_req),
        .charger_wake(charger_wake), .chg_en(chg_en), .dsg_en(dsg_en),
        .ilim_req(ilim_req), .derate_req(derate_req), .fault_n(fault_n),
        .fault_code(fault_code), .evt_counts(evt_counts)
    );

    int n_chk = 0, n_fail = 0;
    bit cmp_on = 0;

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int m_dc [6];
    int m_ev [7];
    int m_st, m_tmr, m_code;
    int q [6];
    int fl [6];
    int pk, ns;
    bit trip;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_dc[i]) m_dc[i] = 0;
            foreach (m_ev[i]) m_ev[i] = 0;
            m_st = M_RUN; m_tmr = 0; m_code = 0;
        end else begin
            fl = '{int'(flag_rev), int'(flag_bkf), int'(flag_ov), int'(flag_ot), int'(flag_oc), int'(flag_uv)};
            foreach (q[i]) q[i] = (m_dc[i] == LIMS[i]) ? 1 : 0;
            pk = 0;
            foreach (q[i]) if (pk == 0 && q[i] == 1) pk = i + 2;
            if (flag_short) pk = 1;
            trip = 0;
            if (flag_short && m_st != M_SCL) trip = 1;
            else if (pk != 0 && m_st == M_RUN) trip = 1;
            else if (pk != 0 && (m_st == M_UVW || m_st == M_OCL || m_st == M_OTD) && pk < m_code) trip = 1;
            ns = m_st;
            if (trip) begin
                if (pk == 1) ns = M_SCL;
                else if (pk == 2 || pk == 3) ns = M_ISO;
                else if (pk == 4) ns = M_OVL;
                else if (pk == 5) ns = M_OTD;
                else if (pk == 6) ns = M_OCL;
                else ns = M_UVW;
                m_code = pk;
                if (m_ev[pk-1] < MAXC) m_ev[pk-1]++;
            end else if (m_st == M_UVW || m_st == M_OCL || m_st == M_OTD) begin
                int qi, dl;
                qi = (m_st == M_UVW) ? q[5] : (m_st == M_OCL) ? q[4] : q[3];
                dl = (m_st == M_UVW) ? UV_DLY : (m_st == M_OCL) ? OC_DLY : OT_DLY;
                if (qi == 0) ns = M_RUN;
                else if (m_tmr + 1 >= dl) ns = (m_st == M_UVW) ? M_UVO : (m_st == M_OCL) ? M_OCO : M_OTO;
                else m_tmr++;
            end else if (m_st == M_SCL) begin
                if (clear_req && !flag_short) ns = M_RUN;
            end else if (m_st == M_OVL) begin
                if (clear_req && ov_hys_ok) ns = M_RUN;
            end else if (m_st == M_UVO) begin
                if (charger_wake) ns = M_RUN;
            end else if (m_st == M_OCO) begin
                if (clear_req) ns = M_RUN;
            end else if (m_st == M_OTO) begin
                if (!flag_ot) ns = M_RUN;
            end else if (m_st == M_ISO) begin
                if (flag_rev || flag_bkf) m_tmr = 0;
                else if (m_tmr + 1 >= ISO_HOLD) ns = M_RUN;
                else m_tmr++;
            end
            if (ns != m_st) m_tmr = 0;
            m_st = ns;
            foreach (m_dc[i]) m_dc[i] = (fl[i] == 0) ? 0 : ((m_dc[i] < LIMS[i]) ? m_dc[i] + 1 : m_dc[i]);
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            bit on;
            on = (m_st == M_RUN || m_st == M_UVW || m_st == M_OCL || m_st == M_OTD);
            chk("R2 chg_en vs model", chg_en, on);
            chk("R2 dsg_en vs model", dsg_en, on);
            chk("R4 ilim_req vs model", ilim_req, m_st == M_OCL);
            chk("R6 derate_req vs model", derate_req, m_st == M_OTD);
            chk("R8 fault_n vs model", fault_n, m_st == M_RUN);
            chk("R9 fault_code vs model", fault_code, m_code);
            for (int k = 0; k < 7; k++)
                chk("R10 counter vs model", evt_counts[k*CNT_W +: CNT_W], m_ev[k]);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog R11 actual=timeout expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        tick(2);
        rst_n = 1'b1;
        tick(1);
        cmp_on = 1;
        // R11 reset state
        chk("R11 chg_en", chg_en, 1); chk("R11 dsg_en", dsg_en, 1);
        chk("R11 fault_n", fault_n, 1); chk("R11 code", fault_code, 0);
        chk("R11 counts", evt_counts, 0); chk("R11 ilim", ilim_req, 0);

        // R1 short pulses restart the count
        flag_ov = 1; tick(3); flag_ov = 0; tick(1); flag_ov = 1; tick(3);
        chk("R1 no trip on broken run", fault_n, 1);
        flag_ov = 0; tick(2);

        // R2 over-voltage latch
        flag_ov = 1; tick(4);
        chk("R1 no trip before qualify+1", fault_n, 1);
        tick(1);
        chk("R2 ov off", chg_en, 0); chk("R2 ov code", fault_code, 4);
        flag_ov = 0; clear_req = 1; tick(2);
        chk("R2 clear without hysteresis ignored", chg_en, 0);
        ov_hys_ok = 1; tick(1); clear_req = 0; ov_hys_ok = 0;
        chk("R2 released", chg_en, 1);
        tick(2);

        // R3 under-voltage rebound then full off
        flag_uv = 1; tick(7);
        chk("R3 wait keeps on", chg_en, 1); chk("R3 wait fault_n", fault_n, 0);
        chk("R3 code", fault_code, 7);
        tick(3); flag_uv = 0; tick(3);
        chk("R3 rebound returns", fault_n, 1);
        flag_uv = 1; tick(7); tick(9);
        chk("R3 still on before delay", chg_en, 1);
        tick(1);
        chk("R3 off after delay", chg_en, 0);
        flag_uv = 0; clear_req = 1; tick(4); clear_req = 0;
        chk("R3 clear_req ignored in uv off", chg_en, 0);
        charger_wake = 1; tick(1); charger_wake = 0;
        chk("R3 charger wake", chg_en, 1);
        tick(2);

        // R4 over-current
        flag_oc = 1; tick(4);
        chk("R4 limit asserted", ilim_req, 1); chk("R4 still on", chg_en, 1);
        chk("R4 code", fault_code, 6);
        tick(7); chk("R4 on before delay", chg_en, 1);
        tick(1); chk("R4 off after delay", dsg_en, 0); chk("R4 limit dropped", ilim_req, 0);
        flag_oc = 0; tick(2); chk("R4 stays off", chg_en, 0);
        clear_req = 1; tick(1); clear_req = 0;
        chk("R4 clear", chg_en, 1);
        tick(2);

        // R5 short-circuit
        flag_short = 1; tick(1);
        chk("R5 immediate off", chg_en, 0); chk("R5 code", fault_code, 1);
        clear_req = 1; tick(2);
        chk("R5 clear blocked while short", chg_en, 0);
        flag_short = 0; tick(1); clear_req = 0;
        chk("R5 cleared", chg_en, 1);
        tick(2);

        // R6 over-temperature
        flag_ot = 1; tick(6);
        chk("R6 derate", derate_req, 1); chk("R6 on while derating", chg_en, 1);
        tick(11); chk("R6 on before delay", chg_en, 1);
        tick(1); chk("R6 off", chg_en, 0); chk("R6 derate off", derate_req, 0);
        flag_ot = 0; tick(1);
        chk("R6 auto retry", chg_en, 1); chk("R6 fault_n", fault_n, 1);
        tick(2);

        // R7 reverse and backfeed
        flag_rev = 1; tick(3);
        chk("R7 rev off", dsg_en, 0); chk("R7 rev code", fault_code, 2);
        tick(2); flag_rev = 0; tick(5);
        chk("R7 held before timeout", chg_en, 0);
        tick(1); chk("R7 released", chg_en, 1);
        flag_bkf = 1; tick(4);
        chk("R7 bkf off", chg_en, 0); chk("R7 bkf code", fault_code, 3);
        flag_bkf = 0; tick(6); chk("R7 bkf released", chg_en, 1);
        tick(2);

        // R9 priority and preemption
        flag_oc = 1; flag_ov = 1; tick(4);
        chk("R9 oc first", fault_code, 6);
        tick(1);
        chk("R9 ov preempts oc", fault_code, 4); chk("R9 off", chg_en, 0);
        flag_oc = 0; flag_ov = 0; ov_hys_ok = 1; clear_req = 1; tick(1);
        ov_hys_ok = 0; clear_req = 0; tick(2);
        flag_bkf = 1; flag_oc = 1; tick(4);
        chk("R9 simultaneous lowest code wins", fault_code, 3);
        flag_bkf = 0; flag_oc = 0; tick(7);
        flag_oc = 1; tick(4); flag_short = 1; tick(1);
        chk("R9 short preempts limit", fault_code, 1);
        flag_short = 0; flag_oc = 0; clear_req = 1; tick(1); clear_req = 0; tick(2);

        // R10 saturation
        for (int k = 0; k < 17; k++) begin
            flag_short = 1; tick(1); flag_short = 0; clear_req = 1; tick(1); clear_req = 0;
        end
        tick(1);
        chk("R10 short counter saturates", evt_counts[0 +: CNT_W], MAXC);
        chk("R10 uv counter field", evt_counts[6*CNT_W +: CNT_W], 2);

        tick(2);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule